// File: doc/BRIEF.md
# Trimmed RC Oscillator Controller with Output Divider

This block is the digital side of a low-frequency on-chip RC oscillator with a nominal rate of 128 kHz. It holds one 32-bit memory-mapped control word. The word carries a signed 5-bit trim code, a 5-bit divide selector, a standby keep-alive bit and a read-only running flag. The trim code goes to the analog oscillator, and the block gates the oscillator's enable according to the device power mode. The raw oscillator clock enters the block, is synchronised into the system clock domain and is divided down. The result is a single-cycle divided clock enable.

At power-on reset the applied trim comes from a factory value on an input port, which is latched while reset is held. The register readback of the trim field stays zero until software first writes that field. From then on the written value is both applied and read back. Byte-lane write strobes let software update the upper half of the word (divider and keep-alive) without disturbing the trim. A change of the divide factor takes effect only at the next divided-clock boundary, so the output never produces a short period.

Top module: `rc_osc_ctrl`

## Requirements
- R1: While reset is held, the readback word is 0, `div_tick_o` is 0, `osc_en_o` is 1, and `trim_code_o` equals `fact_trim_i`. The factory value latched during reset stays applied after reset even if the port changes.
- R2: Until the trim field has been written, readback bits [4:0] read 0, and `trim_code_o` keeps the latched factory code.
- R3: A write with strobe bit 0 set stores `bus_wdata_i[4:0]` as a two's complement trim code (-16 = 5'b10000, +15 = 5'b01111). The code then appears on `trim_code_o` and in readback bits [4:0].
- R4: A write whose strobe bit 0 is clear does not change `trim_code_o` or the trim readback.
- R5: A divide field value N in bits [28:24] (written under strobe bit 3) gives one `div_tick_o` pulse every N+1 oscillator periods, from 1 (N=0) to 32 (N=31).
- R6: A divide change written in the middle of a divided period does not alter that period. The new factor applies from the following boundary.
- R7: `osc_en_o` is 1 one cycle after `mode_standby_i` is 0. In standby it follows the keep-alive bit 16 (written under strobe bit 2).
- R8: Readback bit 20 is 1 while oscillator edges arrive no more than `ACT_TIMEOUT` system clocks apart, and becomes 0 once the oscillator stops. Writes to bit 20 have no effect.
- R9: All bits other than [4:0], 16, 20 and [28:24] read as 0 regardless of what is written to them.
- R10: `div_tick_o` is a single-cycle pulse and is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| fact_trim_i | input | 5 | Factory trim code, latched while reset is held |
| mode_standby_i | input | 1 | Device is in standby mode |
| osc_raw_i | input | 1 | Raw oscillator clock (asynchronous) |
| bus_wr_i | input | 1 | Register write request |
| bus_wstrb_i | input | 4 | Byte-lane write strobes |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Registered readback of the control word |
| trim_code_o | output | 5 | Trim code applied to the oscillator |
| osc_en_o | output | 1 | Oscillator enable |
| div_tick_o | output | 1 | Divided clock enable pulse |

## Verification
Assertions check the following on every cycle. The hidden-trim readback stays zero and the factory code stays stable before the first trim write. An upper-half write leaves the trim state untouched. The divider counter never passes the active factor, and the active factor only reloads at a boundary. The mode gating of the enable holds, and the running flag rises and falls with edges and timeouts. The divided pulse is never stretched. Only the bench scenarios show the following: the actual period length for each divide factor, that a change in the middle of a period completes the old period first, the full signed trim range on the output, and the status flag dropping after the oscillator is stopped in standby.

// File: rtl/rc_osc_pkg.sv
package rc_osc_pkg;

  localparam int DATA_W   = 32;
  localparam int STRB_W   = DATA_W / 8;
  localparam int TRIM_W   = 5;
  localparam int DIV_W    = 5;

  // Field placement inside the control word
  localparam int TRIM_LSB = 0;
  localparam int STBY_BIT = 16;
  localparam int STAT_BIT = 20;
  localparam int DIV_LSB  = 24;

  localparam logic [DATA_W-1:0] TRIM_MASK = DATA_W'(((1 << TRIM_W) - 1) << TRIM_LSB);
  localparam logic [DATA_W-1:0] DIV_MASK  = DATA_W'(((1 << DIV_W) - 1) << DIV_LSB);
  localparam logic [DATA_W-1:0] STBY_MASK = DATA_W'(1) << STBY_BIT;
  localparam logic [DATA_W-1:0] STAT_MASK = DATA_W'(1) << STAT_BIT;
  localparam logic [DATA_W-1:0] USED_MASK = TRIM_MASK | DIV_MASK | STBY_MASK | STAT_MASK;

  typedef logic [TRIM_W-1:0] trim_t;
  typedef logic [DIV_W-1:0]  div_t;

endpackage

// File: rtl/rc_osc_edge_sync.sv
module rc_osc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= 1'b0;
    else     chain_q[0] <= async_i;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[s] <= 1'b0;
        else     chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;

  AST_RISE_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o); // R10

endmodule

// File: rtl/rc_osc_divider.sv
module rc_osc_divider
  import rc_osc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  div_t div_sel_i,
  output logic div_tick_o
);

  div_t cnt_q;
  div_t cur_q;
  logic at_end;

  assign at_end = (cnt_q == cur_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      cur_q      <= div_sel_i;
      div_tick_o <= 1'b0;
    end else begin
      div_tick_o <= 1'b0;
      if (tick_i) begin
        if (at_end) begin
          cnt_q      <= '0;
          cur_q      <= div_sel_i;
          div_tick_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= cur_q); // R5
  AST_FACTOR_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !(tick_i && at_end) |=> $stable(cur_q)); // R6
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    div_tick_o |=> !div_tick_o); // R10

endmodule

// File: rtl/rc_osc_activity.sv
module rc_osc_activity #(
  parameter int ACT_TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  output logic running_o
);

  localparam int IDLE_W = $clog2(ACT_TIMEOUT + 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(ACT_TIMEOUT);

  logic [IDLE_W-1:0] idle_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q    <= '0;
      running_o <= 1'b0;
    end else if (tick_i) begin
      idle_q    <= '0;
      running_o <= 1'b1;
    end else if (idle_q == IDLE_MAX) begin
      running_o <= 1'b0;
    end else begin
      idle_q <= idle_q + 1'b1;
    end
  end

  AST_EDGE_SETS_RUN: assert property (@(posedge clk) disable iff (rst)
    tick_i |=> running_o); // R8
  AST_TIMEOUT_CLEARS_RUN: assert property (@(posedge clk) disable iff (rst)
    (idle_q == IDLE_MAX && !tick_i) |=> !running_o); // R8

endmodule

// File: rtl/rc_osc_regs.sv
module rc_osc_regs
  import rc_osc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  trim_t             fact_trim_i,
  input  logic              wr_i,
  input  logic [STRB_W-1:0] wstrb_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              status_i,
  output trim_t             trim_code_o,
  output div_t              div_sel_o,
  output logic              stby_en_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] bit_we;
  logic              trim_we, div_we, stby_we;
  trim_t             trim_new;
  div_t              div_new;
  logic              stby_new;

  trim_t             fact_q;
  trim_t             trim_sw_q;
  logic              trim_written_q;
  logic [DATA_W-1:0] rd_next;

  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit_we
      assign bit_we[b] = wr_i & wstrb_i[b / 8];
    end
  endgenerate

  assign trim_we  = |(bit_we & TRIM_MASK);
  assign div_we   = |(bit_we & DIV_MASK);
  assign stby_we  = |(bit_we & STBY_MASK);
  assign trim_new = TRIM_W'((wdata_i & TRIM_MASK) >> TRIM_LSB);
  assign div_new  = DIV_W'((wdata_i & DIV_MASK) >> DIV_LSB);
  assign stby_new = |(wdata_i & STBY_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      fact_q         <= fact_trim_i;
      trim_sw_q      <= '0;
      trim_written_q <= 1'b0;
      div_sel_o      <= '0;
      stby_en_o      <= 1'b0;
    end else begin
      if (trim_we) begin
        trim_sw_q      <= trim_new;
        trim_written_q <= 1'b1;
      end
      if (div_we)  div_sel_o <= div_new;
      if (stby_we) stby_en_o <= stby_new;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) trim_code_o <= fact_trim_i;
    else     trim_code_o <= trim_written_q ? trim_sw_q : fact_q;
  end

  always_comb begin
    rd_next = '0;
    rd_next[TRIM_LSB +: TRIM_W] = trim_written_q ? trim_sw_q : '0;
    rd_next[DIV_LSB +: DIV_W]   = div_sel_o;
    rd_next[STBY_BIT]           = stby_en_o;
    rd_next[STAT_BIT]           = status_i;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_next;
  end

  AST_TRIM_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !trim_written_q |=> rdata_o[TRIM_LSB +: TRIM_W] == '0); // R2
  AST_FACTORY_HELD: assert property (@(posedge clk) disable iff (rst)
    (!trim_written_q && !$past(rst)) |-> trim_code_o == fact_q); // R2
  AST_UPPER_KEEPS_TRIM: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !wstrb_i[0]) |=> ($stable(trim_sw_q) && $stable(trim_written_q))); // R4
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rdata_o & ~USED_MASK) == '0); // R9

endmodule

// File: rtl/rc_osc_ctrl.sv
module rc_osc_ctrl
  import rc_osc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ACT_TIMEOUT = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [4:0]  fact_trim_i,
  input  logic        mode_standby_i,
  input  logic        osc_raw_i,
  input  logic        bus_wr_i,
  input  logic [3:0]  bus_wstrb_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic [4:0]  trim_code_o,
  output logic        osc_en_o,
  output logic        div_tick_o
);

  logic osc_rise;
  logic running;
  div_t div_sel;
  logic stby_en;

  rc_osc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (osc_raw_i),
    .rise_o  (osc_rise)
  );

  rc_osc_activity #(.ACT_TIMEOUT(ACT_TIMEOUT)) u_act (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (osc_rise),
    .running_o (running)
  );

  rc_osc_regs u_regs (
    .clk         (clk),
    .rst         (rst),
    .fact_trim_i (fact_trim_i),
    .wr_i        (bus_wr_i),
    .wstrb_i     (bus_wstrb_i),
    .wdata_i     (bus_wdata_i),
    .status_i    (running),
    .trim_code_o (trim_code_o),
    .div_sel_o   (div_sel),
    .stby_en_o   (stby_en),
    .rdata_o     (bus_rdata_o)
  );

  rc_osc_divider u_div (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (osc_rise),
    .div_sel_i  (div_sel),
    .div_tick_o (div_tick_o)
  );

  always_ff @(posedge clk) begin
    if (rst) osc_en_o <= 1'b1;
    else     osc_en_o <= ~mode_standby_i | stby_en;
  end

  AST_AWAKE_ENABLES: assert property (@(posedge clk) disable iff (rst)
    !mode_standby_i |=> osc_en_o); // R7
  AST_STANDBY_GATES: assert property (@(posedge clk) disable iff (rst)
    (mode_standby_i && !stby_en) |=> !osc_en_o); // R7

endmodule

// File: tb/rc_osc_ctrl_tb.sv
`timescale 1ns/1ps
module rc_osc_ctrl_tb;

  localparam int HALF_OSC = 4;   // oscillator half period in clk cycles (scaled model)
  localparam int OSC_CYC  = 2 * HALF_OSC;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  fact_trim = 5'b10110;
  logic        mode_standby = 1'b0;
  logic        osc_raw = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_wstrb = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  trim_code;
  logic        osc_en;
  logic        div_tick;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pulse_n = 0;
  int pulse_t [64];
  int b2b = 0;
  logic prev_tick = 1'b0;

  always #2.5 clk = ~clk;

  rc_osc_ctrl u_dut (
    .clk(clk), .rst(rst), .fact_trim_i(fact_trim), .mode_standby_i(mode_standby),
    .osc_raw_i(osc_raw), .bus_wr_i(bus_wr), .bus_wstrb_i(bus_wstrb),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .trim_code_o(trim_code),
    .osc_en_o(osc_en), .div_tick_o(div_tick)
  );

  // Behavioural oscillator: toggles only while enabled
  initial begin
    forever begin
      repeat (HALF_OSC) @(posedge clk);
      #1;
      if (osc_en) osc_raw = ~osc_raw;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (div_tick) begin
      if (pulse_n < 64) pulse_t[pulse_n] = cyc;
      pulse_n++;
      if (prev_tick) b2b++;
    end
    prev_tick = div_tick;
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] strb, input logic [31:0] data);
    @(negedge clk);
    bus_wr = 1'b1; bus_wstrb = strb; bus_wdata = data;
    @(negedge clk);
    bus_wr = 1'b0; bus_wstrb = '0; bus_wdata = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_pulses(input int k);
    int guard = 0;
    while (pulse_n < k && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic clear_pulses();
    @(posedge clk);
    pulse_n = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(bus_rdata == 32'h0, "R1 readback in reset", bus_rdata, 32'h0);
    check(trim_code == 5'b10110, "R1 factory trim in reset", {27'h0, trim_code}, 32'h16);
    check(osc_en == 1'b1, "R1 enable in reset", {31'h0, osc_en}, 32'h1);
    check(div_tick == 1'b0, "R1 no pulse in reset", {31'h0, div_tick}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    fact_trim = 5'b00011;
    repeat (4) @(negedge clk);
    check(trim_code == 5'b10110, "R1 factory trim latched", {27'h0, trim_code}, 32'h16);
  endtask

  task automatic t_hidden_trim();
    bus_write(4'b1000, 32'h0200_0000);
    check(bus_rdata[4:0] == 5'h0, "R2 trim reads zero", {27'h0, bus_rdata[4:0]}, 32'h0);
    check(trim_code == 5'b10110, "R2 factory applied", {27'h0, trim_code}, 32'h16);
  endtask

  task automatic t_trim_write();
    bus_write(4'b0001, 32'h0000_0010);
    check(trim_code == 5'b10000, "R3 trim -16 applied", {27'h0, trim_code}, 32'h10);
    check(bus_rdata[4:0] == 5'b10000, "R3 trim -16 readback", {27'h0, bus_rdata[4:0]}, 32'h10);
    bus_write(4'b0001, 32'h0000_000F);
    check(trim_code == 5'b01111, "R3 trim +15 applied", {27'h0, trim_code}, 32'h0F);
    bus_write(4'b0001, 32'h0000_001F);
    check(bus_rdata[4:0] == 5'b11111, "R3 trim -1 readback", {27'h0, bus_rdata[4:0]}, 32'h1F);
  endtask

  task automatic t_upper_only();
    bus_write(4'b1100, 32'h0000_0000);
    check(trim_code == 5'b11111, "R4 trim kept applied", {27'h0, trim_code}, 32'h1F);
    check(bus_rdata[4:0] == 5'b11111, "R4 trim kept readback", {27'h0, bus_rdata[4:0]}, 32'h1F);
  endtask

  task automatic measure_div(input int n);
    int sp;
    bus_write(4'b1000, 32'(n) << 24);
    clear_pulses();
    wait_pulses(4);
    sp = pulse_t[3] - pulse_t[2];
    check(sp == (n + 1) * OSC_CYC, "R5 divided period", 32'(sp), 32'((n + 1) * OSC_CYC));
  endtask

  task automatic t_divide();
    measure_div(0);
    measure_div(3);
    measure_div(31);
  endtask

  task automatic t_div_change();
    int d1, d2;
    bus_write(4'b1000, 32'h0700_0000);
    clear_pulses();
    wait_pulses(3);
    clear_pulses();
    wait_pulses(1);
    repeat (10) @(negedge clk);
    bus_write(4'b1000, 32'h0100_0000);
    wait_pulses(3);
    d1 = pulse_t[1] - pulse_t[0];
    d2 = pulse_t[2] - pulse_t[1];
    check(d1 == 8 * OSC_CYC, "R6 old period completes", 32'(d1), 32'(8 * OSC_CYC));
    check(d2 == 2 * OSC_CYC, "R6 new period after boundary", 32'(d2), 32'(2 * OSC_CYC));
  endtask

  task automatic t_standby();
    check(bus_rdata[20] == 1'b1, "R8 running flag", {31'h0, bus_rdata[20]}, 32'h1);
    bus_write(4'b0100, 32'h0000_0000);
    check(bus_rdata[20] == 1'b1, "R8 status write ignored", {31'h0, bus_rdata[20]}, 32'h1);
    @(negedge clk); mode_standby = 1'b1;
    repeat (2) @(negedge clk);
    check(osc_en == 1'b0, "R7 standby gates enable", {31'h0, osc_en}, 32'h0);
    repeat (150) @(negedge clk);
    check(bus_rdata[20] == 1'b0, "R8 flag drops when stopped", {31'h0, bus_rdata[20]}, 32'h0);
    bus_write(4'b0100, 32'h0001_0000);
    check(osc_en == 1'b1, "R7 keep-alive in standby", {31'h0, osc_en}, 32'h1);
    repeat (40) @(negedge clk);
    check(bus_rdata[20] == 1'b1, "R8 flag returns", {31'h0, bus_rdata[20]}, 32'h1);
    bus_write(4'b0100, 32'h0000_0000);
    @(negedge clk); mode_standby = 1'b0;
    repeat (2) @(negedge clk);
    check(osc_en == 1'b1, "R7 awake enables", {31'h0, osc_en}, 32'h1);
  endtask

  task automatic t_reserved();
    bus_write(4'b1111, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    check((bus_rdata & 32'hE0EE_FFE0) == 32'h0, "R9 reserved read zero", bus_rdata, bus_rdata & 32'h1F11_001F);
    check(bus_rdata[28:24] == 5'h1F && bus_rdata[16], "R9 defined fields written", bus_rdata, 32'h1F11_001F);
  endtask

  initial begin
    t_reset();
    t_hidden_trim();
    t_trim_write();
    t_upper_only();
    t_divide();
    t_div_change();
    t_standby();
    t_reserved();
    check(b2b == 0, "R10 single-cycle pulse", 32'(b2b), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule